// File: doc/BRIEF.md
# I/O Virtual Address Translation Unit

This block translates device I/O virtual addresses (IOVAs) into physical addresses. A single 1 GiB window of IOVA space is mapped through a page directory in memory. The directory is an array of 64-bit entries, one per I/O page. A small fully associative translation cache sits in front of the directory, so repeated accesses to a page need no memory traffic. Software configures the unit through a plain register write/read port. It sets the window base and enable, the window mask, the page size and the directory base, and it can invalidate cached translations over an aligned range with a single purge write.

Translation requests and responses use valid/ready handshakes. `req_ready` is high only while the unit is idle and no register write is present in the same cycle, so exactly one request is in flight at a time. Once `rsp_valid` rises, the response (`rsp_pa` and the three status flags) is held stable until the consumer raises `rsp_ready`. A cache miss raises `mem_req_valid` with the entry address and holds both until `mem_req_ready`. The unit then waits for a single-cycle `mem_rsp_valid` that carries the 64-bit entry. The memory side may stall either phase for any number of cycles.

Top module: `iova_xlate`

## Requirements
- R1: After reset, every register reads zero, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and translation is disabled.
- R2: Register offsets on `reg_addr`: 0x300 is window base, 0x308 is window mask, 0x310 is purge command, 0x318 is page-size code (bits [1:0]), 0x320 is directory base. A read returns the last value written to that offset (page-size code zero-extended).
- R3: Bit 0 of the window base register enables translation. While it is clear, every request completes with `rsp_fault`=1 and no memory read is issued.
- R4: An IOVA is inside the window when (IOVA AND mask) equals the base with bit 0 cleared. An IOVA outside the window faults without a memory read.
- R5: Page-size codes 0, 1, 2, 3 select page shifts of 12, 13, 14 and 16 bits.
- R6: On a cache miss, the entry is read at directory base + ((IOVA − window base) >> shift) × 8. The address is always 8-byte aligned and is held stable until accepted.
- R7: Bit 63 of an entry marks it valid. The physical address is the entry's bits [62:shift] joined with the IOVA's low `shift` bits. A valid fetched entry responds with `rsp_miss`=1. Exactly one status flag is set in every response.
- R8: An entry with bit 63 clear responds with `rsp_fault`=1 and is not cached, so a later request to the same page reads memory again.
- R9: A request whose page is cached responds with `rsp_hit`=1 and the cached address, with no memory read. The cache holds 4 entries, filled in round-robin order with the pointer advancing by one per fill.
- R10: A purge write carries an aligned range base in bits above [5:0] and log2 of the range size in bits [5:0]. Every cached page overlapping that range is invalidated, and pages outside it stay cached.
- R11: Any write to the window base or page-size register invalidates all cached entries before the next request is accepted.
- R12: A response is held stable while `rsp_ready` is low, and no new request is accepted while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_iova | input | ADDR_W | I/O virtual address to translate |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_pa | output | 63 | Translated physical address |
| rsp_hit | output | 1 | Served from the translation cache |
| rsp_miss | output | 1 | Served from a fetched directory entry |
| rsp_fault | output | 1 | Disabled, outside the window, or invalid entry |
| mem_req_valid | output | 1 | Directory entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Byte address of the directory entry |
| mem_rsp_valid | input | 1 | Directory entry data valid |
| mem_rdata | input | 64 | Directory entry |

## Verification
A wrong cache tag, a stale valid bit or a misplaced round-robin pointer stays hidden until the affected page is next requested. It then shows at once as a wrong hit/miss flag, a memory read that should not occur, or a stale physical address. The bench therefore changes directory contents after pages are cached, so that stale data differs from fresh data. A purge or flush that clears too little returns an old address on the very next request to that page. One that clears too much shows as an extra memory read. Index or page-size decode errors appear on `mem_req_addr` in the first miss after configuration.

// File: rtl/iox_pkg.sv
package iox_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } iox_state_e;

  localparam logic [11:0] OFS_BASE  = 12'h300;
  localparam logic [11:0] OFS_MASK  = 12'h308;
  localparam logic [11:0] OFS_PURGE = 12'h310;
  localparam logic [11:0] OFS_CFG   = 12'h318;
  localparam logic [11:0] OFS_DIR   = 12'h320;

  // non-linear page-size code: 4K, 8K, 16K, 64K
  function automatic logic [4:0] page_shift(input logic [1:0] code);
    case (code)
      2'd0:    page_shift = 5'd12;
      2'd1:    page_shift = 5'd13;
      2'd2:    page_shift = 5'd14;
      default: page_shift = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/iox_regs.sv
module iox_regs
  import iox_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic              xl_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_mask,
  output logic [ADDR_W-1:0] dir_base,
  output logic [4:0]        pg_shift,
  output logic              inv_all,
  output logic              purge_go,
  output logic [ADDR_W-1:0] purge_base,
  output logic [5:0]        purge_lg
);

  logic [63:0] base_q, mask_q, purge_q, dir_q;
  logic [1:0]  cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      purge_q <= '0;
      dir_q   <= '0;
      cfg_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_BASE:  base_q  <= wdata;
        OFS_MASK:  mask_q  <= wdata;
        OFS_PURGE: purge_q <= wdata;
        OFS_CFG:   cfg_q   <= wdata[1:0];
        OFS_DIR:   dir_q   <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_BASE:  rdata = base_q;
      OFS_MASK:  rdata = mask_q;
      OFS_PURGE: rdata = purge_q;
      OFS_CFG:   rdata = {62'd0, cfg_q};
      OFS_DIR:   rdata = dir_q;
      default:   rdata = '0;
    endcase
  end

  assign xl_en      = base_q[0];
  assign win_base   = {base_q[ADDR_W-1:1], 1'b0};
  assign win_mask   = mask_q[ADDR_W-1:0];
  assign dir_base   = {dir_q[ADDR_W-1:3], 3'b000};
  assign pg_shift   = page_shift(cfg_q);
  assign inv_all    = wr_en && ((addr == OFS_BASE) || (addr == OFS_CFG));
  assign purge_go   = wr_en && (addr == OFS_PURGE);
  assign purge_base = {wdata[ADDR_W-1:6], 6'd0};
  assign purge_lg   = wdata[5:0];

endmodule

// File: rtl/iox_window.sv
module iox_window #(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] iova,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [4:0]        pg_shift,
  output logic              in_win,
  output logic [ADDR_W-1:0] page_num,
  output logic [ADDR_W-1:0] dir_addr
);

  logic [ADDR_W-1:0] rel, idx;

  assign in_win   = (iova & win_mask) == win_base;
  assign rel      = iova - win_base;
  assign idx      = rel >> pg_shift;
  assign dir_addr = dir_base + (idx << 3);
  assign page_num = iova >> pg_shift;

endmodule

// File: rtl/iox_tlb.sv
module iox_tlb #(
  parameter int ADDR_W  = 40,
  parameter int ENTRIES = 4,
  parameter int PA_W    = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_page,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_ppage,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_page,
  input  logic [PA_W-1:0]   fill_ppage,
  input  logic              inv_all,
  input  logic              purge_go,
  input  logic [ADDR_W-1:0] purge_base,
  input  logic [5:0]        purge_lg,
  input  logic [4:0]        pg_shift
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] v_q;
  logic [ADDR_W-1:0]  tag_q   [ENTRIES];
  logic [PA_W-1:0]    ppage_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ADDR_W-1:0]  cmp_mask;
  logic [ENTRIES-1:0] kill;

  always_comb begin
    lk_hit   = 1'b0;
    lk_ppage = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (v_q[e] && (tag_q[e] == lk_page)) begin
        lk_hit   = 1'b1;
        lk_ppage = ppage_q[e];
      end
    end
  end

  // bits compared for overlap: above both the range size and the page size
  always_comb begin
    for (int i = 0; i < ADDR_W; i++)
      cmp_mask[i] = (i >= int'(purge_lg)) && (i >= int'(pg_shift));
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_kill
    assign kill[e] = (((tag_q[e] << pg_shift) ^ purge_base) & cmp_mask) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      ptr_q <= '0;
    end else begin
      if (fill_en) begin
        tag_q[ptr_q]   <= fill_page;
        ppage_q[ptr_q] <= fill_ppage;
        v_q[ptr_q]     <= 1'b1;
        ptr_q          <= (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
      end
      if (inv_all)       v_q <= '0;
      else if (purge_go) v_q <= v_q & ~kill;
    end
  end

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iox_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int TLB_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [11:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_iova,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [62:0]       rsp_pa,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rdata
);

  localparam int PA_W = 63;

  logic              xl_en, inv_all, purge_go, in_win, lk_hit, fill_en;
  logic [ADDR_W-1:0] win_base, win_mask, dir_base, purge_base, page_num, dir_addr, off_cur;
  logic [4:0]        pg_shift;
  logic [5:0]        purge_lg;
  logic [PA_W-1:0]   lk_ppage;

  iox_state_e        state_q;
  logic [ADDR_W-1:0] iova_q, off_q, page_q, addr_q;
  logic              stale_q, hit_q, miss_q, fault_q;
  logic [PA_W-1:0]   pa_q;
  logic              accept, inv_any;

  function automatic logic [PA_W-1:0] pa_join(input logic [PA_W-1:0] pp,
                                              input logic [ADDR_W-1:0] va,
                                              input logic [ADDR_W-1:0] off);
    pa_join = (pp & ~PA_W'(off)) | PA_W'(va & off);
  endfunction

  iox_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .xl_en(xl_en), .win_base(win_base), .win_mask(win_mask),
    .dir_base(dir_base), .pg_shift(pg_shift), .inv_all(inv_all), .purge_go(purge_go),
    .purge_base(purge_base), .purge_lg(purge_lg)
  );

  iox_window #(.ADDR_W(ADDR_W)) u_win (
    .iova(req_iova), .win_base(win_base), .win_mask(win_mask), .dir_base(dir_base),
    .pg_shift(pg_shift), .in_win(in_win), .page_num(page_num), .dir_addr(dir_addr)
  );

  iox_tlb #(.ADDR_W(ADDR_W), .ENTRIES(TLB_ENTRIES), .PA_W(PA_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_page(page_num), .lk_hit(lk_hit), .lk_ppage(lk_ppage),
    .fill_en(fill_en), .fill_page(page_q), .fill_ppage(mem_rdata[62:0] & ~PA_W'(off_q)),
    .inv_all(inv_all), .purge_go(purge_go), .purge_base(purge_base),
    .purge_lg(purge_lg), .pg_shift(pg_shift)
  );

  assign off_cur       = ~({ADDR_W{1'b1}} << pg_shift);
  assign req_ready     = (state_q == ST_IDLE) && !reg_wr_en;
  assign accept        = req_valid && req_ready;
  assign inv_any       = inv_all || purge_go;
  assign fill_en       = (state_q == ST_WAIT) && mem_rsp_valid && mem_rdata[63] && !stale_q;
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_hit       = hit_q;
  assign rsp_miss      = miss_q;
  assign rsp_fault     = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iova_q  <= '0;
      off_q   <= '0;
      page_q  <= '0;
      addr_q  <= '0;
      stale_q <= 1'b0;
      pa_q    <= '0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          stale_q <= 1'b0;
          iova_q  <= req_iova;
          off_q   <= off_cur;
          page_q  <= page_num;
          addr_q  <= dir_addr;
          hit_q   <= 1'b0;
          miss_q  <= 1'b0;
          fault_q <= 1'b0;
          pa_q    <= '0;
          if (!xl_en || !in_win) begin
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else if (lk_hit) begin
            hit_q   <= 1'b1;
            pa_q    <= pa_join(lk_ppage, req_iova, off_cur);
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (inv_any) stale_q <= 1'b1;
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (inv_any) stale_q <= 1'b1;
          if (mem_rsp_valid) begin
            state_q <= ST_RESP;
            if (mem_rdata[63]) begin
              miss_q <= 1'b1;
              pa_q   <= pa_join(mem_rdata[62:0], iova_q, off_q);
            end else begin
              fault_q <= 1'b1;
            end
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iox_chk.sv
module iox_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [62:0]       rsp_pa,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) &&
                                $stable({rsp_hit, rsp_miss, rsp_fault}));

  p_busy_no_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  p_one_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

  p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_fetch_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

endmodule

bind iova_xlate iox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/iova_xlate_bench.sv
module iova_xlate_bench;
  localparam int AW = 40;
  localparam logic [11:0] A_BASE = 12'h300, A_MASK = 12'h308, A_PURGE = 12'h310,
                          A_CFG = 12'h318, A_DIR = 12'h320;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_iova = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_hit, rsp_miss, rsp_fault;
  logic [62:0] rsp_pa;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [63:0] mem_rdata = '0;

  always #4 clk = ~clk;

  iova_xlate u_iova_xlate (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_iova(req_iova), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;

  // shadow configuration and reference cache model
  logic [63:0] r_base = '0, r_mask = '0, r_dir = '0;
  logic [1:0]  r_cfg = '0;
  logic          m_v  [4];
  logic [AW-1:0] m_tag[4];
  logic [62:0]   m_pp [4];
  int            m_ptr = 0;
  logic          dm_v [64];
  logic [62:0]   dm_pa[64];

  function automatic int shf(input logic [1:0] c);
    case (c)
      2'd0: return 12;
      2'd1: return 13;
      2'd2: return 14;
      default: return 16;
    endcase
  endfunction

  function automatic logic [AW-1:0] offm(input int s);
    return ~({AW{1'b1}} << s);
  endfunction

  function automatic logic [63:0] dm_read(input logic [AW-1:0] a);
    logic [AW-1:0] i;
    i = (a - r_dir[AW-1:0]) >> 3;
    if (i < 64) return {dm_v[i[5:0]], dm_pa[i[5:0]]};
    return 64'd0;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    int s;
    logic [AW-1:0] pb, va, cm;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    s = shf(r_cfg);
    if (a == A_BASE || a == A_CFG) begin
      for (int e = 0; e < 4; e++) m_v[e] = 1'b0;
    end
    if (a == A_PURGE) begin
      pb = d[AW-1:0] & ~AW'(63);
      for (int i = 0; i < AW; i++) cm[i] = (i >= int'(d[5:0])) && (i >= s);
      for (int e = 0; e < 4; e++) begin
        va = m_tag[e] << s;
        if (m_v[e] && (((va ^ pb) & cm) == '0)) m_v[e] = 1'b0;
      end
    end
    case (a)
      A_BASE: r_base = d;
      A_MASK: r_mask = d;
      A_CFG:  r_cfg  = d[1:0];
      A_DIR:  r_dir  = d;
      default: ;
    endcase
  endtask

  // kind: 0 hit, 1 miss, 2 fault
  task automatic xlate(input logic [AW-1:0] iova, input string req, output int kind);
    int s, ek, hold;
    logic [AW-1:0] wb, off, pg, eaddr, gaddr;
    logic [62:0] epa, pa1;
    logic eread, gread;
    logic [63:0] ent;
    s = shf(r_cfg); off = offm(s);
    wb = r_base[AW-1:0] & ~AW'(1);
    pg = iova >> s;
    eread = 1'b0; epa = '0; ek = 2; eaddr = '0;
    if (r_base[0] && ((iova & r_mask[AW-1:0]) == wb)) begin
      ek = -1;
      for (int e = 0; e < 4; e++)
        if (m_v[e] && m_tag[e] == pg) begin
          ek = 0; epa = (m_pp[e] & ~63'(off)) | 63'(iova & off);
        end
      if (ek < 0) begin
        eread = 1'b1;
        eaddr = r_dir[AW-1:0] + (((iova - wb) >> s) << 3);
        ent = dm_read(eaddr);
        if (ent[63]) begin
          ek = 1; epa = (ent[62:0] & ~63'(off)) | 63'(iova & off);
          m_v[m_ptr] = 1'b1; m_tag[m_ptr] = pg; m_pp[m_ptr] = ent[62:0] & ~63'(off);
          m_ptr = (m_ptr + 1) % 4;
        end else ek = 2;
      end
    end
    @(negedge clk);
    req_iova = iova; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    gread = 1'b0; gaddr = '0;
    for (int c = 0; c < 64 && !rsp_valid; c++) begin
      if (mem_req_valid && !gread) begin
        gread = 1'b1; gaddr = mem_req_addr;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_rdata = dm_read(gaddr); mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else @(negedge clk);
    end
    check(req, "response arrived", 64'(rsp_valid), 64'd1);
    check("R12", "busy blocks requests", 64'(req_ready), 64'd0);
    kind = rsp_hit ? 0 : (rsp_miss ? 1 : 2);
    check(req, "status kind", 64'(kind), 64'(ek));
    check(req, "physical address", 64'(rsp_pa), 64'(epa));
    check(req, "memory read issued", 64'(gread), 64'(eread));
    if (eread) check("R6", "entry address", 64'(gaddr), 64'(eaddr));
    pa1 = rsp_pa;
    hold = $urandom_range(0, 2);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check("R12", "held response", {rsp_valid, pa1 ^ rsp_pa}, 64'h8000_0000_0000_0000);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int k;
    logic [AW-1:0] wb;
    void'($urandom(32'd20240611));
    for (int e = 0; e < 4; e++) begin m_v[e] = 1'b0; m_tag[e] = '0; m_pp[e] = '0; end
    for (int i = 0; i < 64; i++) begin
      dm_v[i] = 1'b1; dm_pa[i] = {$urandom, $urandom};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    reg_addr = A_BASE; #1 check("R1", "base reads zero", reg_rdata, 64'd0);
    reg_addr = A_CFG;  #1 check("R1", "cfg reads zero", reg_rdata, 64'd0);

    // R3 disabled unit faults without memory traffic
    xlate(40'h4000_1000, "R3", k);
    check("R3", "disabled fault", 64'(k), 64'd2);

    // R2 program and read back
    wr(A_MASK, 64'hFFFF_FFFF_C000_0000);
    wr(A_DIR,  64'h0000_0012_3450_0000);
    wr(A_CFG,  64'd0);
    wr(A_BASE, 64'h0000_0000_4000_0001);
    wr(A_PURGE, 64'h0000_0000_4000_000C);
    reg_addr = A_MASK;  #1 check("R2", "mask readback", reg_rdata, 64'hFFFF_FFFF_C000_0000);
    reg_addr = A_DIR;   #1 check("R2", "dir readback", reg_rdata, 64'h0000_0012_3450_0000);
    reg_addr = A_BASE;  #1 check("R2", "base readback", reg_rdata, 64'h0000_0000_4000_0001);
    reg_addr = A_PURGE; #1 check("R2", "purge readback", reg_rdata, 64'h0000_0000_4000_000C);
    wb = 40'h4000_0000;

    // R4 outside window, both sides
    xlate(40'h8000_0000, "R4", k);  check("R4", "above window", 64'(k), 64'd2);
    xlate(40'h3FFF_F000, "R4", k);  check("R4", "below window", 64'(k), 64'd2);

    // R5 / R6 / R7 each page-size code
    for (int c = 0; c < 4; c++) begin
      wr(A_CFG, 64'(c));
      xlate(wb + (40'd3 << shf(2'(c))) + 40'h123, "R5", k);
      check("R7", "fetched is miss", 64'(k), 64'd1);
    end

    // R8 invalid entry faults and is not cached
    dm_v[5] = 1'b0;
    xlate(wb + (40'd5 << 16), "R8", k); check("R8", "invalid faults", 64'(k), 64'd2);
    xlate(wb + (40'd5 << 16), "R8", k); check("R8", "refetched", 64'(k), 64'd2);
    dm_v[5] = 1'b1;

    // R9 hit and round-robin replacement
    wr(A_CFG, 64'd0);
    for (int p = 10; p < 14; p++) xlate(wb + (40'(p) << 12), "R9", k);
    xlate(wb + (40'd10 << 12) + 40'h7, "R9", k); check("R9", "cached hit", 64'(k), 64'd0);
    xlate(wb + (40'd14 << 12), "R9", k);
    xlate(wb + (40'd10 << 12), "R9", k); check("R9", "oldest replaced", 64'(k), 64'd1);

    // R10 purge: stale until purged, outside range untouched
    dm_pa[12] = ~dm_pa[12];
    xlate(wb + (40'd12 << 12), "R10", k); check("R10", "stale hit", 64'(k), 64'd0);
    wr(A_PURGE, {24'd0, wb + (40'd12 << 12)} | 64'd12);
    xlate(wb + (40'd13 << 12), "R10", k); check("R10", "outside kept", 64'(k), 64'd0);
    xlate(wb + (40'd12 << 12), "R10", k); check("R10", "purged refetch", 64'(k), 64'd1);

    // R11 base rewrite flushes everything
    wr(A_BASE, 64'h0000_0000_4000_0001);
    xlate(wb + (40'd13 << 12), "R11", k); check("R11", "flushed", 64'(k), 64'd1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r, s;
      logic [AW-1:0] pbase;
      int lg;
      r = $urandom_range(0, 99);
      s = shf(r_cfg);
      if (r < 5) wr(A_CFG, 64'($urandom_range(0, 3)));
      else if (r < 12) begin
        lg = $urandom_range(12, 22);
        pbase = (wb + (40'($urandom_range(0, 63)) << s)) & ~offm(lg);
        wr(A_PURGE, 64'(pbase) | 64'(lg));
      end else if (r < 20) begin
        int i = $urandom_range(0, 63);
        dm_pa[i] = {$urandom, $urandom};
        dm_v[i] = ($urandom_range(0, 4) != 0);
      end else if (r < 28)
        xlate(wb + 40'h4000_0000 + 40'($urandom), "R4", k);
      else
        xlate(wb + (40'($urandom_range(0, 63)) << s) + (40'($urandom) & offm(s)),
              "R9", k);
    end

    // R3 writing zero disables
    wr(A_BASE, 64'd0);
    xlate(wb + 40'h10, "R3", k); check("R3", "zero base disables", 64'(k), 64'd2);

    finish_run();
  end
endmodule